// File: doc/BRIEF.md
# DRAM Activate Timing Tracker

This block decides, for every rank and bank of a DRAM channel, whether a row activate may be issued now. It watches the commands the controller has already put on the bus: activate, precharge of one bank, precharge of all banks, and refresh. Each command carries a rank and a bank. From this stream it keeps countdowns for the minimum command-to-activate spacings and a rolling record of recent activates per rank. It presents one registered activate-allowed bit per rank-bank pair. A scheduler in front of it reads these bits and only picks activates whose bit is set.

All spacings are programmable and counted in DRAM clocks. One activate-to-activate spacing applies per rank. A precharge-to-activate spacing is kept for each bank. Separate spacings apply per rank after a precharge-all and after a refresh. A per-rank window allows at most four activates within a programmable number of clocks, and a single enable switches this window limit off. The number of ranks, the banks per rank and every counter width are parameters.

Timing convention used throughout: edges are numbered by the clock. A command sampled at edge k with a spacing of N clocks drives the affected allowed bits low in the output registered at edges k+1 through k+N. The bits rise again at edge k+N+1. Outputs registered at edge j reflect only commands sampled at edges before j.

Top module: `act_timing_gate`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) sets every act_ok bit to 1 at that edge and forgets all earlier commands.
- R2: An activate (cmd_type 0) to rank r sampled at edge k with cfg_rrd = N clears every act_ok bit of rank r in the outputs registered at edges k+1 to k+N. Bits of other ranks are not affected.
- R3: A precharge (cmd_type 1) to rank r, bank b sampled at edge k with cfg_rp = N clears only bit r*BANKS+b of act_ok, for edges k+1 to k+N.
- R4: A precharge-all (cmd_type 2) to rank r sampled at edge k with cfg_prea = N clears all bits of rank r for edges k+1 to k+N.
- R5: A refresh (cmd_type 3) to rank r sampled at edge k with the 9-bit cfg_rfc = N clears all bits of rank r for edges k+1 to k+N.
- R6: A spacing value of 0 places no constraint: such a command never clears any act_ok bit.
- R7: When cfg_win_en is 1 at edge j, the bits of rank r are cleared at edge j if the last four activates to rank r were all sampled at edges k with j <= k + W. Here W is the value of cfg_win_len at that activate's edge.
- R8: When cfg_win_en is 0 at edge j, the activate window has no effect on the output registered at edge j. Activates are still recorded, so that turning the window back on applies it to them.
- R9: Overlapping constraints of one kind do not shorten each other. A bit stays low until the latest end time among all commands that apply to it, each end time using the spacing in force when its command was sampled.
- R10: A command with cmd_valid low has no effect. act_ok bit r*BANKS+b belongs to rank r, bank b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DRAM clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A command is launched at this edge |
| cmd_type | input | 2 | 0 activate, 1 precharge, 2 precharge-all, 3 refresh |
| cmd_rank | input | RANK_IW | Target rank of the command |
| cmd_bank | input | BANK_IW | Target bank (used by activate and precharge) |
| cfg_win_en | input | 1 | 1 enables the four-activate window limit |
| cfg_win_len | input | WIN_W (6) | Window length in clocks |
| cfg_rrd | input | RRD_W (4) | Activate-to-activate spacing, same rank |
| cfg_rp | input | RP_W (4) | Precharge-to-activate spacing, same bank |
| cfg_prea | input | PREA_W (4) | Precharge-all-to-activate spacing |
| cfg_rfc | input | RFC_W (9) | Refresh-to-activate spacing |
| act_ok | output | RANKS*BANKS | Registered activate-allowed bits, index rank*BANKS+bank |

## Verification
Each spacing is first run in isolation with only one command kind active. This separates rank-wide clearing (activate, precharge-all, refresh) from the single-bit clearing of a bank precharge, and checks that the untouched rank stays open. Bursts of activates spaced just inside and just outside the window length check the four-deep rolling record. Toggling the window enable during such a burst shows that the record keeps filling while the limit is off. Back-to-back commands with a shrinking spacing test the no-shortening rule. Zero spacings and commands with valid low test the no-effect cases. A long run of random commands and configurations is then compared cycle by cycle against a timestamp model.

// File: rtl/act_gate_pkg.sv
// Package: shared command encoding and index-width helper for the
// activate timing tracker. Assumes a 2-bit command code on the bus.
package act_gate_pkg;

    typedef enum logic [1:0] {
        CMD_ACT  = 2'd0,
        CMD_PRE  = 2'd1,
        CMD_PREA = 2'd2,
        CMD_REF  = 2'd3
    } act_cmd_e;

    // Width of an index into n items, never less than one bit.
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/act_spacing_ctr.sv
// Module: act_spacing_ctr
// A single command-to-activate countdown. On a hit it loads the larger of
// the new spacing and the decremented current value, so that a later
// command can never shorten an earlier constraint. busy is high while the
// count is nonzero. Assumes hit and load_val are sampled on the same edge.
module act_spacing_ctr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hit,
    input  logic [W-1:0] load_val,
    output logic         busy
);

    logic [W-1:0] cnt;
    logic [W-1:0] dec;

    // Next value when no reload happens: count down to zero and hold.
    always_comb begin
        dec = (cnt == '0) ? '0 : cnt - 1'b1;
    end

    // Countdown register with max-reload on a matching command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (hit && (load_val > dec)) begin
            cnt <= load_val;
        end else begin
            cnt <= dec;
        end
    end

    assign busy = (cnt != '0);

    // Without a command the remaining wait never grows.
    assert_no_growth_without_cmd_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        !hit |=> (cnt <= $past(cnt))
    );

    // A command always leaves at least its own spacing outstanding.
    assert_reload_not_shorter_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        hit |=> (cnt >= $past(load_val))
    );

    // A zero spacing on an idle counter leaves it idle.
    assert_zero_spacing_free_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        (hit && load_val == '0 && cnt == '0) |=> !busy
    );

endmodule

// File: rtl/act_window_track.sv
// Module: act_window_track
// Rolling record of the last SLOTS activates of one rank. Each slot holds
// the clocks remaining in that activate's window. A rotating pointer always
// overwrites the oldest slot. The window is closed while every slot is
// still live. Assumes win_len is sampled on the activate edge.
module act_window_track #(
    parameter int SLOTS = 4,
    parameter int W     = 6,
    localparam int PW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         act_hit,
    input  logic [W-1:0] win_len,
    output logic         open
);

    logic [PW-1:0]    ptr;
    logic [SLOTS-1:0] live;

    // Advance the oldest-slot pointer on every activate, wrapping at SLOTS.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (act_hit) begin
            ptr <= (ptr == PW'(SLOTS - 1)) ? '0 : ptr + 1'b1;
        end
    end

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic [W-1:0] left;

        // Slot countdown: load on an activate aimed at this slot, else decay.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                left <= '0;
            end else if (act_hit && ptr == PW'(s)) begin
                left <= win_len;
            end else if (left != '0) begin
                left <= left - 1'b1;
            end
        end

        assign live[s] = (left != '0);
    end

    assign open = ~&live;

    // An activate with a nonzero window leaves at least one slot live.
    assert_window_recorded_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        (act_hit && win_len != '0) |=> ($countones(live) >= 1)
    );

    // Without an activate no slot comes back to life.
    assert_no_spurious_slot_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        !act_hit |=> ($countones(live) <= $countones($past(live)))
    );

endmodule

// File: rtl/act_rank_gate.sv
// Module: act_rank_gate
// All activate constraints of one rank: rank-wide activate, precharge-all
// and refresh countdowns, one precharge countdown per bank, and the
// activate window. Produces the unregistered allowed vector for the
// rank's banks. Assumes the hit strobes are already qualified by rank.
module act_rank_gate #(
    parameter int BANKS     = 8,
    parameter int BANK_IW   = 3,
    parameter int WIN_W     = 6,
    parameter int RRD_W     = 4,
    parameter int RP_W      = 4,
    parameter int PREA_W    = 4,
    parameter int RFC_W     = 9,
    parameter int ACT_LIMIT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hit_act,
    input  logic               hit_pre,
    input  logic               hit_prea,
    input  logic               hit_ref,
    input  logic [BANK_IW-1:0] bank,
    input  logic               cfg_win_en,
    input  logic [WIN_W-1:0]   cfg_win_len,
    input  logic [RRD_W-1:0]   cfg_rrd,
    input  logic [RP_W-1:0]    cfg_rp,
    input  logic [PREA_W-1:0]  cfg_prea,
    input  logic [RFC_W-1:0]   cfg_rfc,
    output logic [BANKS-1:0]   bank_ok,
    output logic               win_open
);

    logic rrd_busy;
    logic prea_busy;
    logic ref_busy;
    logic rank_free;
    logic [BANKS-1:0] rp_busy;

    act_spacing_ctr #(.W(RRD_W)) u_rrd (
        .clk(clk), .rst_n(rst_n), .hit(hit_act),
        .load_val(cfg_rrd), .busy(rrd_busy)
    );

    act_spacing_ctr #(.W(PREA_W)) u_prea (
        .clk(clk), .rst_n(rst_n), .hit(hit_prea),
        .load_val(cfg_prea), .busy(prea_busy)
    );

    act_spacing_ctr #(.W(RFC_W)) u_ref (
        .clk(clk), .rst_n(rst_n), .hit(hit_ref),
        .load_val(cfg_rfc), .busy(ref_busy)
    );

    act_window_track #(.SLOTS(ACT_LIMIT), .W(WIN_W)) u_win (
        .clk(clk), .rst_n(rst_n), .act_hit(hit_act),
        .win_len(cfg_win_len), .open(win_open)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic bank_hit;
        assign bank_hit = hit_pre && (bank == BANK_IW'(b));

        act_spacing_ctr #(.W(RP_W)) u_rp (
            .clk(clk), .rst_n(rst_n), .hit(bank_hit),
            .load_val(cfg_rp), .busy(rp_busy[b])
        );
    end

    // Rank-level permission: no rank countdown running and the window open
    // (or disabled).
    always_comb begin
        rank_free = !rrd_busy && !prea_busy && !ref_busy
                    && (!cfg_win_en || win_open);
    end

    // Per-bank permission adds that bank's own precharge spacing.
    always_comb begin
        bank_ok = {BANKS{rank_free}} & ~rp_busy;
    end

endmodule

// File: rtl/act_timing_gate.sv
// Module: act_timing_gate (top)
// Decodes launched commands by kind and rank, feeds one act_rank_gate per
// rank and registers the combined allowed vector once per clock. A command
// sampled at edge k is visible in act_ok from edge k+1. Assumes at most
// one command per clock.
module act_timing_gate
    import act_gate_pkg::*;
#(
    parameter int RANKS     = 2,
    parameter int BANKS     = 8,
    parameter int WIN_W     = 6,
    parameter int RRD_W     = 4,
    parameter int RP_W      = 4,
    parameter int PREA_W    = 4,
    parameter int RFC_W     = 9,
    parameter int ACT_LIMIT = 4,
    localparam int RANK_IW  = idx_w(RANKS),
    localparam int BANK_IW  = idx_w(BANKS),
    localparam int PAIRS    = RANKS * BANKS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_type,
    input  logic [RANK_IW-1:0] cmd_rank,
    input  logic [BANK_IW-1:0] cmd_bank,
    input  logic               cfg_win_en,
    input  logic [WIN_W-1:0]   cfg_win_len,
    input  logic [RRD_W-1:0]   cfg_rrd,
    input  logic [RP_W-1:0]    cfg_rp,
    input  logic [PREA_W-1:0]  cfg_prea,
    input  logic [RFC_W-1:0]   cfg_rfc,
    output logic [PAIRS-1:0]   act_ok
);

    act_cmd_e         kind;
    logic [PAIRS-1:0] ok_comb;
    logic [RANKS-1:0] win_open;

    assign kind = act_cmd_e'(cmd_type);

    for (genvar r = 0; r < RANKS; r++) begin : g_rank
        logic sel;
        assign sel = cmd_valid && (cmd_rank == RANK_IW'(r));

        act_rank_gate #(
            .BANKS(BANKS), .BANK_IW(BANK_IW), .WIN_W(WIN_W),
            .RRD_W(RRD_W), .RP_W(RP_W), .PREA_W(PREA_W),
            .RFC_W(RFC_W), .ACT_LIMIT(ACT_LIMIT)
        ) u_rank (
            .clk(clk), .rst_n(rst_n),
            .hit_act (sel && kind == CMD_ACT),
            .hit_pre (sel && kind == CMD_PRE),
            .hit_prea(sel && kind == CMD_PREA),
            .hit_ref (sel && kind == CMD_REF),
            .bank(cmd_bank),
            .cfg_win_en(cfg_win_en), .cfg_win_len(cfg_win_len),
            .cfg_rrd(cfg_rrd), .cfg_rp(cfg_rp),
            .cfg_prea(cfg_prea), .cfg_rfc(cfg_rfc),
            .bank_ok(ok_comb[r*BANKS +: BANKS]),
            .win_open(win_open[r])
        );

        // A closed, enabled window blocks the whole rank at the next edge.
        assert_window_blocks_rank_R7: assert property (
            @(posedge clk) disable iff (!rst_n)
            (cfg_win_en && !win_open[r]) |=> (act_ok[r*BANKS +: BANKS] == '0)
        );

        // A refresh with nonzero spacing blocks the rank in the next output.
        assert_refresh_blocks_rank_R5: assert property (
            @(posedge clk) disable iff (!rst_n)
            (sel && kind == CMD_REF && cfg_rfc != '0)
                |=> ##1 (act_ok[r*BANKS +: BANKS] == '0)
        );

        // A precharge-all with nonzero spacing blocks the rank likewise.
        assert_prea_blocks_rank_R4: assert property (
            @(posedge clk) disable iff (!rst_n)
            (sel && kind == CMD_PREA && cfg_prea != '0)
                |=> ##1 (act_ok[r*BANKS +: BANKS] == '0)
        );
    end

    // Output register: all allowed in reset, else the combined conditions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_ok <= '1;
        end else begin
            act_ok <= ok_comb;
        end
    end

    // Reset opens every rank-bank pair.
    assert_reset_all_open_R1: assert property (
        @(posedge clk) !rst_n |=> (act_ok == '1)
    );

endmodule

// File: tb/tb_act_timing_gate.sv
// Bench: behavioural timestamp model (end times and queues) compared with
// act_ok after every clock edge. Inputs change on the falling edge.
module tb_act_timing_gate;

    localparam int NR  = 2;
    localparam int NB  = 8;
    localparam int LIM = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_type = 2'd0;
    logic [0:0]  cmd_rank = 1'b0;
    logic [2:0]  cmd_bank = 3'd0;
    logic        cfg_win_en = 1'b0;
    logic [5:0]  cfg_win_len = 6'd0;
    logic [3:0]  cfg_rrd = 4'd0;
    logic [3:0]  cfg_rp = 4'd0;
    logic [3:0]  cfg_prea = 4'd0;
    logic [8:0]  cfg_rfc = 9'd0;
    logic [NR*NB-1:0] act_ok;

    act_timing_gate #(.RANKS(NR), .BANKS(NB)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
        .cmd_rank(cmd_rank), .cmd_bank(cmd_bank), .cfg_win_en(cfg_win_en),
        .cfg_win_len(cfg_win_len), .cfg_rrd(cfg_rrd), .cfg_rp(cfg_rp),
        .cfg_prea(cfg_prea), .cfg_rfc(cfg_rfc), .act_ok(act_ok)
    );

    always #5 clk = ~clk;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;
    string cur_req = "R1";

    int rrd_end  [NR];
    int prea_end [NR];
    int rfc_end  [NR];
    int rp_end   [NR][NB];
    int faw_q    [NR][$];
    logic [NR*NB-1:0] expv;

    task automatic model_clear();
        for (int r = 0; r < NR; r++) begin
            rrd_end[r] = -1; prea_end[r] = -1; rfc_end[r] = -1;
            for (int b = 0; b < NB; b++) rp_end[r][b] = -1;
            faw_q[r].delete();
        end
    endtask

    // One clock: model the edge, then compare on the falling edge.
    task automatic tick();
        @(posedge clk);
        cyc++;
        #1;
        if (!rst_n) begin
            expv = '1;
            model_clear();
        end else begin
            for (int r = 0; r < NR; r++) begin
                logic full;
                full = 1'b0;
                if (cfg_win_en && faw_q[r].size() >= LIM) begin
                    full = 1'b1;
                    foreach (faw_q[r][i]) if (faw_q[r][i] < cyc) full = 1'b0;
                end
                for (int b = 0; b < NB; b++) begin
                    expv[r*NB+b] = !(cyc <= rrd_end[r]) && !(cyc <= prea_end[r])
                                   && !(cyc <= rfc_end[r]) && !(cyc <= rp_end[r][b])
                                   && !full;
                end
            end
            if (cmd_valid) begin
                int r;
                int e;
                r = int'(cmd_rank);
                case (cmd_type)
                    2'd0: begin
                        e = cyc + int'(cfg_rrd);
                        if (e > rrd_end[r]) rrd_end[r] = e;
                        faw_q[r].push_back(cyc + int'(cfg_win_len));
                        if (faw_q[r].size() > LIM) void'(faw_q[r].pop_front());
                    end
                    2'd1: begin
                        e = cyc + int'(cfg_rp);
                        if (e > rp_end[r][cmd_bank]) rp_end[r][cmd_bank] = e;
                    end
                    2'd2: begin
                        e = cyc + int'(cfg_prea);
                        if (e > prea_end[r]) prea_end[r] = e;
                    end
                    default: begin
                        e = cyc + int'(cfg_rfc);
                        if (e > rfc_end[r]) rfc_end[r] = e;
                    end
                endcase
            end
        end
        @(negedge clk);
        n_checks++;
        if (act_ok !== expv) begin
            n_fails++;
            $display("FAIL %s cycle %0d: act_ok=%b expected %b", cur_req, cyc, act_ok, expv);
        end
    endtask

    task automatic cmd(input logic [1:0] t, input int r, input int b);
        cmd_valid = 1'b1; cmd_type = t;
        cmd_rank = 1'(r); cmd_bank = 3'(b);
        tick();
        cmd_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic zero_cfg();
        cfg_win_en = 0; cfg_win_len = 0; cfg_rrd = 0;
        cfg_rp = 0; cfg_prea = 0; cfg_rfc = 0;
    endtask

    initial begin
        #2_000_000;
        n_fails++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        model_clear();
        // R1: reset state
        cur_req = "R1";
        rst_n = 0; idle(3);
        rst_n = 1; idle(2);

        // R2: activate spacing, rank-wide, other rank untouched
        cur_req = "R2"; zero_cfg(); cfg_rrd = 4'd5;
        cmd(2'd0, 0, 2); idle(8);
        cfg_rrd = 4'd15; cmd(2'd0, 1, 7); idle(18);

        // R3: precharge spacing per bank
        cur_req = "R3"; zero_cfg(); cfg_rp = 4'd7;
        cmd(2'd1, 1, 3); cmd(2'd1, 0, 0); idle(10);

        // R4: precharge-all spacing
        cur_req = "R4"; zero_cfg(); cfg_prea = 4'd6;
        cmd(2'd2, 0, 5); idle(9);

        // R5: refresh spacing, 9-bit value
        cur_req = "R5"; zero_cfg(); cfg_rfc = 9'd300;
        cmd(2'd3, 1, 0); idle(305);

        // R6: zero spacings, no constraint
        cur_req = "R6"; zero_cfg(); cfg_win_en = 1;
        for (int i = 0; i < 8; i++) cmd(2'(i % 4), i % 2, i);
        idle(3);

        // R7: activate window, bursts inside and outside the window
        cur_req = "R7"; zero_cfg(); cfg_win_en = 1; cfg_win_len = 6'd20; cfg_rrd = 4'd2;
        for (int i = 0; i < 6; i++) begin cmd(2'd0, 0, i); idle(2); end
        idle(25);
        cfg_win_len = 6'd10;
        for (int i = 0; i < 6; i++) begin cmd(2'd0, 1, i); idle(2); end
        idle(15);
        cfg_win_len = 6'd63;
        for (int i = 0; i < 5; i++) cmd(2'd0, 0, 1);
        idle(70);

        // R8: window disabled, then re-enabled over recorded activates
        cur_req = "R8"; zero_cfg(); cfg_win_len = 6'd30;
        for (int i = 0; i < 4; i++) cmd(2'd0, 1, i);
        idle(5);
        cfg_win_en = 1; idle(5);
        cfg_win_en = 0; idle(5);
        cfg_win_en = 1; idle(25);

        // R9: overlapping commands do not shorten
        cur_req = "R9"; zero_cfg(); cfg_rfc = 9'd50;
        cmd(2'd3, 0, 0); cfg_rfc = 9'd5; cmd(2'd3, 0, 0); idle(55);
        cfg_rp = 4'd12; cmd(2'd1, 1, 4); cfg_rp = 4'd1; cmd(2'd1, 1, 4); idle(15);

        // R1: reset mid-constraint clears everything
        cur_req = "R1"; cfg_rfc = 9'd200; cmd(2'd3, 1, 0); idle(3);
        rst_n = 0; idle(2); rst_n = 1; idle(4);

        // R10: valid low ignored, then random traffic and configurations
        cur_req = "R10"; zero_cfg(); cfg_rrd = 4'd9; cfg_rfc = 9'd40; cfg_rp = 4'd9;
        for (int i = 0; i < 8; i++) begin
            cmd_valid = 0; cmd_type = 2'(i % 4); cmd_rank = 1'(i % 2); cmd_bank = 3'(i);
            tick();
        end
        for (int blk = 0; blk < 12; blk++) begin
            cfg_win_en  = 1'($urandom_range(0, 1));
            cfg_win_len = 6'($urandom_range(0, 40));
            cfg_rrd     = 4'($urandom_range(0, 15));
            cfg_rp      = 4'($urandom_range(0, 15));
            cfg_prea    = 4'($urandom_range(0, 15));
            cfg_rfc     = 9'($urandom_range(0, 120));
            for (int i = 0; i < 250; i++) begin
                int pick;
                pick = int'($urandom_range(0, 9));
                cmd_valid = (pick < 5);
                cmd_type  = (pick < 3) ? 2'd0 : 2'($urandom_range(0, 3));
                cmd_rank  = 1'($urandom_range(0, 1));
                cmd_bank  = 3'($urandom_range(0, 7));
                if (i % 60 == 59) cfg_win_en = ~cfg_win_en;
                tick();
            end
        end
        cmd_valid = 0; idle(5);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule